// File: doc/BRIEF.md
# Per-Pin Input Debouncer with Edge Interrupt

This block cleans up one already-synchronized input pin. It holds a stable level and updates it only after the raw input has disagreed with it on enough consecutive samples. Samples are taken on a periodic sample strobe. The block then raises a single-cycle interrupt pulse for the edges the selected trigger mode cares about. A polarity bit flips on every accepted change, so the detector is always armed for the opposite edge. The reported input value is the stable level, inverted when the active-low trigger is chosen.

After reset, the block spends one cycle capturing the pin. It then waits idle until the first strobe on which the raw pin differs from the stable level. From that strobe on, it runs a strobe-paced confirmation loop. Separate reload counts apply to rising and falling confirmations. With filtering turned off, every change on the pin is taken at once.

Top module: `pin_debounce`

## Requirements
- R1: One cycle after reset is released, the stable level and the polarity bit both equal the raw pin sampled in that cycle. No interrupt is raised.
- R2: With filtering on, the stable level never changes on a cycle without a sample strobe. While idle, a difference between pin and stable level starts a check only on a strobe, and that starting strobe does not count as a sample.
- R3: During a check, each strobe whose sample differs from the stable level decrements the counter. The change is accepted when the counter reaches zero. The counter is loaded with RISE_LOAD (default 2) when the stable level is 0 and with FALL_LOAD (default 2) when it is 1.
- R4: During a check, a strobe whose sample agrees with the stable level reloads the counter, so a short glitch is rejected.
- R5: On an accepted change, `irq` is high for exactly one clock cycle, in the cycle after the accepting edge. It fires if `both_edges`=1, or if `trig_low`=1 and the new level is 0, or if `trig_low`=0 and the new level is 1. Otherwise it stays low.
- R6: With filtering on, `polarity` toggles on every accepted change and always equals the stable level.
- R7: `level_out` is the stable level XOR `trig_low`.
- R8: With `filter_en`=0, a pin change is taken on the next clock edge with no strobe needed. `irq` follows R5. `polarity` toggles only when `both_edges`=1.
- R9: A check in progress is never restarted. After a reload it keeps running, so a later disagreement is accepted after the reload count of strobes, with no extra starting strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe, one cycle wide |
| pin_raw | input | 1 | Synchronized raw pin |
| filter_en | input | 1 | 1 = debounce, 0 = take changes immediately |
| trig_low | input | 1 | 1 = active-low trigger and inverted report |
| both_edges | input | 1 | 1 = interrupt on both edges |
| level_out | output | 1 | Reported input value |
| polarity | output | 1 | Edge-arming polarity bit |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume the mode inputs `filter_en`, `trig_low` and `both_edges` stay constant between resets. The polarity-equals-level and single-cycle-pulse properties depend on this. The stimulus changes modes only while reset is held. The random phases toggle the pin and the strobe freely within each fixed mode, and a bench model predicts every output cycle by cycle.

// File: rtl/pin_debounce.sv
module pin_debounce #(
  parameter int RISE_LOAD = 2,
  parameter int FALL_LOAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_raw,
  input  logic filter_en,
  input  logic trig_low,
  input  logic both_edges,
  output logic level_out,
  output logic polarity,
  output logic irq
);
  localparam int MAXL = (RISE_LOAD > FALL_LOAD) ? RISE_LOAD : FALL_LOAD;
  localparam int CW   = $clog2(MAXL + 1);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_CHECK} st_t;

  st_t           st;
  logic          state_q, pol_q, irq_q;
  logic [CW-1:0] cnt_q;

  wire differ  = pin_raw != state_q;
  wire fire_ok = both_edges | (trig_low ? ~pin_raw : pin_raw);

  function automatic logic [CW-1:0] load_for(input logic lvl);
    return lvl ? CW'(FALL_LOAD) : CW'(RISE_LOAD);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_INIT;
      state_q <= 1'b0;
      pol_q   <= 1'b0;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        S_INIT: begin
          state_q <= pin_raw;
          pol_q   <= pin_raw;
          cnt_q   <= load_for(pin_raw);
          st      <= S_IDLE;
        end
        S_IDLE: begin
          if (filter_en) begin
            if (tick && differ) st <= S_CHECK;
          end else if (differ) begin
            state_q <= pin_raw;
            irq_q   <= fire_ok;
            if (both_edges) pol_q <= ~pol_q;
          end
        end
        S_CHECK: begin
          if (tick) begin
            if (!differ) begin
              cnt_q <= load_for(state_q);
            end else if (cnt_q == CW'(1)) begin
              state_q <= pin_raw;
              pol_q   <= ~pol_q;
              irq_q   <= fire_ok;
              cnt_q   <= load_for(pin_raw);
              st      <= S_IDLE;
            end else begin
              cnt_q <= cnt_q - CW'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign level_out = state_q ^ trig_low;
  assign polarity  = pol_q;
  assign irq       = irq_q;

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_en && irq_q) |=> !irq_q);

  assert_irq_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (state_q != $past(state_q)));

  assert_pol_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_en && st != S_INIT) |-> (pol_q == state_q));

  assert_no_tick_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_en && $past(st) != S_INIT && !$past(tick)) |-> $stable(state_q));

  assert_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK) |-> (cnt_q != '0 && cnt_q <= CW'(MAXL)));
endmodule

// File: tb/tb_pin_debounce.sv
`timescale 1ns/1ps
module tb_pin_debounce;
  logic clk = 0, rst_n = 0, tick = 0, pin_raw = 0;
  logic filter_en = 1, trig_low = 0, both_edges = 0;
  logic level_out, polarity, irq;
  int checks = 0, failures = 0;
  logic cmp_en = 0;

  pin_debounce dut (.clk(clk), .rst_n(rst_n), .tick(tick), .pin_raw(pin_raw),
    .filter_en(filter_en), .trig_low(trig_low), .both_edges(both_edges),
    .level_out(level_out), .polarity(polarity), .irq(irq));

  always #2 clk = ~clk;

  // reference model built from the requirements
  logic m_init, m_chk, m_st, m_pol, m_irq;
  int   m_cnt;
  function automatic int ld(input logic lvl);
    return lvl ? 2 : 2;
  endfunction
  function automatic logic want_irq(input logic nl);
    return both_edges | (trig_low ? ~nl : nl);
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      m_init <= 1; m_chk <= 0; m_st <= 0; m_pol <= 0; m_irq <= 0; m_cnt <= 0;
    end else begin
      m_irq <= 0;
      if (m_init) begin
        m_init <= 0; m_st <= pin_raw; m_pol <= pin_raw; m_cnt <= ld(pin_raw);
      end else if (!filter_en) begin
        if (pin_raw != m_st) begin
          m_st <= pin_raw; m_irq <= want_irq(pin_raw);
          if (both_edges) m_pol <= ~m_pol;
        end
      end else if (!m_chk) begin
        if (tick && pin_raw != m_st) m_chk <= 1;
      end else if (tick) begin
        if (pin_raw == m_st) m_cnt <= ld(m_st);
        else if (m_cnt - 1 == 0) begin
          m_st <= pin_raw; m_pol <= ~m_pol; m_irq <= want_irq(pin_raw);
          m_cnt <= ld(pin_raw); m_chk <= 0;
        end else m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_en && !m_init) begin
    chk("R7 level_out model", level_out, m_st ^ trig_low);
    chk("R6 polarity model", polarity, m_pol);
    chk("R5 irq model", irq, m_irq);
  end

  task automatic do_reset(input logic fe, input logic tl, input logic be, input logic p);
    @(negedge clk);
    rst_n = 0; tick = 0; filter_en = fe; trig_low = tl; both_edges = be; pin_raw = p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cmp_en = 1;
    // R1: init from pin
    do_reset(1, 0, 0, 1);
    chk("R1 level after init hi", level_out, 1);
    chk("R1 pol after init hi", polarity, 1);
    chk("R1 no irq", irq, 0);
    do_reset(1, 0, 0, 0);
    chk("R1 level after init lo", level_out, 0);
    chk("R1 pol after init lo", polarity, 0);
    // R2: no strobe, no change
    pin_raw = 1; idle(10);
    chk("R2 no change without tick", level_out, 0);
    do_tick(); do_tick();
    chk("R3 not yet accepted", level_out, 0);
    do_tick();
    chk("R3 accepted rise", level_out, 1);
    chk("R5 irq on rise", irq, 1);
    chk("R6 pol toggled", polarity, 1);
    idle(1);
    chk("R5 irq one cycle", irq, 0);
    // R5: falling edge, trig high, no irq
    pin_raw = 0; do_tick(); do_tick(); do_tick();
    chk("R3 accepted fall", level_out, 0);
    chk("R5 no irq on fall", irq, 0);
    chk("R6 pol back", polarity, 0);
    // R4 / R9: glitch then reload, check continues
    pin_raw = 1; do_tick(); do_tick();
    pin_raw = 0; do_tick();
    pin_raw = 1; do_tick();
    chk("R4 glitch rejected", level_out, 0);
    do_tick();
    chk("R9 accepted without restart", level_out, 1);
    chk("R5 irq after resumed check", irq, 1);
    // R7 active-low
    do_reset(1, 1, 0, 0);
    chk("R7 inverted report", level_out, 1);
    pin_raw = 1; do_tick(); do_tick(); do_tick();
    chk("R7 inverted after rise", level_out, 0);
    chk("R5 no irq active-low rise", irq, 0);
    pin_raw = 0; do_tick(); do_tick(); do_tick();
    chk("R5 irq active-low fall", irq, 1);
    // both edges filtered
    do_reset(1, 0, 1, 1);
    pin_raw = 0; do_tick(); do_tick(); do_tick();
    chk("R5 both-edges fall irq", irq, 1);
    // R8: no filtering
    do_reset(0, 0, 1, 0);
    pin_raw = 1; idle(1);
    chk("R8 immediate level", level_out, 1);
    chk("R8 immediate irq", irq, 1);
    chk("R8 pol toggles both-edges", polarity, 1);
    pin_raw = 0; idle(1);
    chk("R8 irq on fall both-edges", irq, 1);
    chk("R8 pol back", polarity, 0);
    do_reset(0, 0, 0, 0);
    pin_raw = 1; idle(1);
    chk("R8 pol held single-edge", polarity, 0);
    chk("R8 irq rise single-edge", irq, 1);
    pin_raw = 0; idle(1);
    chk("R8 no irq fall single-edge", irq, 0);
    // random phases against the model
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[0] | cfg[2], cfg[1], cfg[2] ^ cfg[0], $urandom_range(0, 1));
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 7) == 0) pin_raw = ~pin_raw;
        tick = ($urandom_range(0, 2) == 0);
        @(negedge clk);
      end
      tick = 0;
    end
    cmp_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule